// File: doc/BRIEF.md
# Hypercube Node Router with Fixed Dimension Order

This block is the switching logic of one node in a binary hypercube of 2^DIM nodes. Each node has an address of DIM bits and one link per dimension. The link on dimension k leads to the node whose address differs from this one in bit k alone. The node also has a local port, which injects packets into the network and delivers packets out of it. Every input port owns a register of one flit. A packet is carried as a single flit, and its header holds the destination address and a hop counter.

For each held packet, the router XORs the destination with its own address. It forwards on the link of the lowest set bit of that result. When the result is zero, it hands the packet to the local port. Because every packet fixes its differing address bits from the lowest index upward, the dependencies between channels cannot form a cycle, so the network cannot deadlock. Each output has a valid/ready handshake. When several held packets compete for one output, a fixed priority decides which one goes. A packet whose output is not ready stays where it is.

Top module: `cube_router_node`

## Requirements
- R1: A flit is FLIT_W = PAY_W + HOP_W + DIM bits wide. The destination address is in bits [DIM-1:0]. The hop counter is in the next HOP_W bits, with HOP_W = clog2(DIM+1). The payload fills the top PAY_W bits. Port p of a flattened bus uses bits [p*FLIT_W +: FLIT_W]. Ports 0..DIM-1 are links, and port DIM is local.
- R2: When a held packet's destination differs from node_id, the packet is offered only on link k, where k is the lowest bit position in which the destination and node_id differ.
- R3: When the destination equals node_id, the packet is offered on the local output with its hop counter unchanged.
- R4: Each forward on a link adds one to the hop counter. A packet injected with hop 0 arrives with a hop count equal to the Hamming distance between source and destination, which never exceeds DIM.
- R5: Each input port stores one flit. in_ready is high exactly when that store is empty, and a flit is taken on a clock edge where in_valid and in_ready are both high.
- R6: While a packet's chosen output has out_ready low, the packet stays stored, out_valid on that output stays high, and the packet's contents do not change.
- R7: When several stored packets want the same output, the one on the lowest-numbered input port is sent first, and the others wait.
- R8: During reset and just after it, every out_valid is low and every in_ready is high.
- R9: Link k of node n connects to link k of node n XOR 2^k. In the resulting cube, a packet between any pair of nodes is delivered at the destination's local port and crosses exactly as many distinct links as the Hamming distance between the two addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | DIM | Address of this node |
| in_valid | input | DIM+1 | Per input port: a flit is offered |
| in_ready | output | DIM+1 | Per input port: the one-flit store is empty |
| in_flit | input | (DIM+1)*FLIT_W | Flattened incoming flits |
| out_valid | output | DIM+1 | Per output port: a flit is offered |
| out_ready | input | DIM+1 | Per output port: the receiver takes the flit |
| out_flit | output | (DIM+1)*FLIT_W | Flattened outgoing flits |

## Verification
Eight nodes are wired into a three-dimensional cube. Single packets are sent over all 64 source and destination pairs. This separates wrong hop counting, wrong delivery and wrong port wiring, and the self-addressed pairs check that local delivery leaves the hop counter unchanged. A table of chosen pairs also records which links carried each packet: 010 to 111 must pass through 011, and 110 to 001 must pass through 111 and then 101. This is what tells lowest-bit-first correction apart from any other order. Two directed cases follow. In the first, two packets reach one node in the same cycle, which shows the fixed priority. In the second, the eject port is held not-ready, which shows that the packet is held intact.

// File: rtl/cube_pkg.sv
package cube_pkg;

   // upper bound on the cube dimension supported by the node
   localparam int CUBE_MAX_DIM = 16;

   // width of a hop counter that must hold values 0..dim
   function automatic int hop_width(input int dim);
      return (dim < 1) ? 1 : $clog2(dim + 1);
   endfunction

endpackage

// File: rtl/cube_in_slice.sv
module cube_in_slice #(
   parameter int W = 13,
   parameter int DIM = 3,
   parameter int HOP_W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_valid,
   output logic         push_ready,
   input  logic [W-1:0] push_flit,
   input  logic         pop,
   output logic         hold_valid,
   output logic [W-1:0] hold_flit
);

   logic         full_q;
   logic [W-1:0] flit_q;

   // ready depends on state only, so no combinational path crosses the cube
   assign push_ready = !full_q;
   assign hold_valid = full_q;
   assign hold_flit  = flit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
      end else if (push_valid && !full_q) begin
         full_q <= 1'b1;
      end else if (pop) begin
         full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (push_valid && !full_q) begin
         flit_q <= push_flit;
      end
   end

   // R6
   slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !pop) |=> (full_q && $stable(flit_q)));

   // R5
   pop_only_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> full_q);

   // R4
   hop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |-> (flit_q[DIM +: HOP_W] <= HOP_W'(DIM)));

endmodule

// File: rtl/cube_route_sel.sv
module cube_route_sel #(
   parameter int DIM = 3
) (
   input  logic [DIM-1:0] node_id,
   input  logic [DIM-1:0] dest,
   output logic [DIM:0]   sel
);

   logic [DIM-1:0] diff;

   // lowest differing bit picks the link; no difference picks local
   always_comb begin
      diff = node_id ^ dest;
      sel  = {(diff == '0), diff & (~diff + DIM'(1))};
   end

endmodule

// File: rtl/cube_out_arb.sv
module cube_out_arb #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);

   // fixed priority: lowest requesting index wins
   assign grant = req & (~req + N'(1));

   // R7
   grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R7
   grant_when_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> ((grant & req) != '0));

endmodule

// File: rtl/cube_router_node.sv
module cube_router_node #(
   parameter  int DIM    = 3,
   parameter  int PAY_W  = 8,
   localparam int HOP_W  = cube_pkg::hop_width(DIM),
   localparam int FLIT_W = PAY_W + HOP_W + DIM,
   localparam int NP     = DIM + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DIM-1:0]       node_id,
   input  logic [NP-1:0]        in_valid,
   output logic [NP-1:0]        in_ready,
   input  logic [NP*FLIT_W-1:0] in_flit,
   output logic [NP-1:0]        out_valid,
   input  logic [NP-1:0]        out_ready,
   output logic [NP*FLIT_W-1:0] out_flit
);

   localparam int HOP_LO = DIM;
   localparam int PAY_LO = DIM + HOP_W;

   if (DIM < 1 || DIM > cube_pkg::CUBE_MAX_DIM) begin : g_bad_dim
      $error("cube_router_node: DIM out of range");
   end
   if (PAY_W < 1) begin : g_bad_pay
      $error("cube_router_node: PAY_W must be positive");
   end

   logic [NP-1:0]     held;
   logic [FLIT_W-1:0] held_f [NP];
   logic [NP-1:0]     want   [NP];
   logic [NP-1:0]     reqcol [NP];
   logic [NP-1:0]     gnt    [NP];
   logic [NP-1:0]     pop;

   for (genvar i = 0; i < NP; i++) begin : g_in
      cube_in_slice #(.W(FLIT_W), .DIM(DIM), .HOP_W(HOP_W)) u_slice (
         .clk        (clk),
         .rst_n      (rst_n),
         .push_valid (in_valid[i]),
         .push_ready (in_ready[i]),
         .push_flit  (in_flit[i*FLIT_W +: FLIT_W]),
         .pop        (pop[i]),
         .hold_valid (held[i]),
         .hold_flit  (held_f[i])
      );

      cube_route_sel #(.DIM(DIM)) u_route (
         .node_id (node_id),
         .dest    (held_f[i][DIM-1:0]),
         .sel     (want[i])
      );

      // R2
      one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
         held[i] |-> ($countones(want[i]) == 1));
   end

   for (genvar j = 0; j < NP; j++) begin : g_out
      logic [FLIT_W-1:0] pick;

      for (genvar i = 0; i < NP; i++) begin : g_col
         assign reqcol[j][i] = held[i] & want[i][j];
      end

      cube_out_arb #(.N(NP)) u_arb (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (reqcol[j]),
         .grant (gnt[j])
      );

      always_comb begin
         pick = '0;
         for (int i = 0; i < NP; i++) begin
            if (gnt[j][i]) pick = held_f[i];
         end
      end

      assign out_valid[j] = |reqcol[j];

      if (j < DIM) begin : g_link
         localparam logic [DIM-1:0] LOW_MASK = DIM'((1 << j) - 1);
         assign out_flit[j*FLIT_W +: FLIT_W] =
            {pick[FLIT_W-1:PAY_LO], pick[PAY_LO-1:HOP_LO] + HOP_W'(1), pick[DIM-1:0]};

         // R2
         ecube_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[j] |-> ((((out_flit[j*FLIT_W +: DIM] ^ node_id) & LOW_MASK) == '0)
                              && (out_flit[j*FLIT_W + j] != node_id[j])));

         // R4
         link_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[j] |-> (out_flit[j*FLIT_W + HOP_LO +: HOP_W] <= HOP_W'(DIM)));
      end else begin : g_local
         assign out_flit[j*FLIT_W +: FLIT_W] = pick;

         // R3
         local_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[j] |-> (out_flit[j*FLIT_W +: DIM] == node_id));
      end

      // R6
      stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[j] && !out_ready[j]) |=> out_valid[j]);
   end

   always_comb begin
      pop = '0;
      for (int i = 0; i < NP; i++) begin
         for (int j = 0; j < NP; j++) begin
            if (gnt[j][i] && out_ready[j]) pop[i] = 1'b1;
         end
      end
   end

endmodule

// File: tb/test_cube_router_node.sv
module test_cube_router_node;

   localparam int CLK_PERIOD = 10;
   localparam int DIM   = 3;
   localparam int NODES = 1 << DIM;
   localparam int NP    = DIM + 1;
   localparam int PW    = 8;
   localparam int HW    = 2;
   localparam int FW    = PW + HW + DIM;
   localparam int LINKS = NODES * DIM;

   // vector: src[31:29] dst[28:26] hops[25:24] link mask[23:0] (bit n*DIM+k)
   localparam int NVEC = 6;
   localparam logic [31:0] VEC [NVEC] = '{
      {3'd2, 3'd7, 2'd2, 24'h000840},
      {3'd0, 3'd7, 2'd3, 24'h000811},
      {3'd5, 3'd5, 2'd0, 24'h000000},
      {3'd1, 3'd0, 2'd1, 24'h000008},
      {3'd6, 3'd1, 2'd3, 24'h460000},
      {3'd4, 3'd6, 2'd1, 24'h002000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   wire [NP-1:0]    n_iv [NODES];
   wire [NP-1:0]    n_ir [NODES];
   wire [NP-1:0]    n_ov [NODES];
   wire [NP-1:0]    n_or [NODES];
   wire [NP*FW-1:0] n_if [NODES];
   wire [NP*FW-1:0] n_of [NODES];

   logic [NODES-1:0] inj_v = '0;
   logic [NODES-1:0] ej_r  = '1;
   logic [FW-1:0]    inj_f [NODES];

   int total = 0;
   int bad   = 0;

   for (genvar n = 0; n < NODES; n++) begin : g_node
      cube_router_node #(.DIM(DIM), .PAY_W(PW)) i_cube_router_node (
         .clk       (clk),
         .rst_n     (rst_n),
         .node_id   (DIM'(n)),
         .in_valid  (n_iv[n]),
         .in_ready  (n_ir[n]),
         .in_flit   (n_if[n]),
         .out_valid (n_ov[n]),
         .out_ready (n_or[n]),
         .out_flit  (n_of[n])
      );
      for (genvar k = 0; k < DIM; k++) begin : g_lnk
         localparam int NB = n ^ (1 << k);
         assign n_iv[NB][k]            = n_ov[n][k];
         assign n_if[NB][k*FW +: FW]   = n_of[n][k*FW +: FW];
         assign n_or[n][k]             = n_ir[NB][k];
      end
      assign n_iv[n][DIM]          = inj_v[n];
      assign n_if[n][DIM*FW +: FW] = inj_f[n];
      assign n_or[n][DIM]          = ej_r[n];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic send_pkt(input int src, input int dst, input logic [PW-1:0] pay);
      @(negedge clk);
      inj_f[src] = {pay, HW'(0), DIM'(dst)};
      inj_v[src] = 1'b1;
      @(negedge clk);
      inj_v[src] = 1'b0;
   endtask

   task automatic wait_eject(output int node, output logic [FW-1:0] fl,
                             output logic [LINKS-1:0] seen, output bit got);
      got = 1'b0; node = -1; fl = '0; seen = '0;
      for (int c = 0; c < 40 && !got; c++) begin
         for (int n = 0; n < NODES; n++)
            for (int k = 0; k < DIM; k++)
               if (n_ov[n][k]) seen[n*DIM+k] = 1'b1;
         for (int n = 0; n < NODES; n++)
            if (!got && n_ov[n][DIM]) begin
               got = 1'b1; node = n; fl = n_of[n][DIM*FW +: FW];
            end
         if (!got) @(negedge clk);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int node;
      logic [FW-1:0] fl;
      logic [LINKS-1:0] seen;
      bit got;
      for (int n = 0; n < NODES; n++) inj_f[n] = '0;

      // R8: state while reset is held
      repeat (3) @(negedge clk);
      for (int n = 0; n < NODES; n++) begin
         chk(n_ov[n] == '0, "R8", "out_valid in reset", n_ov[n], 0);
         chk(n_ir[n] == '1, "R8", "in_ready in reset", n_ir[n], 4'hf);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk(n_ov[0] == '0 && n_ir[0] == '1, "R8", "after release", {n_ov[0], n_ir[0]}, 8'h0f);

      // table of chosen pairs: R2 order of links, R4 hop count
      for (int v = 0; v < NVEC; v++) begin
         int s, d, h;
         s = int'(VEC[v][31:29]); d = int'(VEC[v][28:26]); h = int'(VEC[v][25:24]);
         send_pkt(s, d, PW'(v + 8'h40));
         wait_eject(node, fl, seen, got);
         chk(got && node == d, "R9", "table eject node", node, d);
         chk(seen == VEC[v][23:0], "R2", "table links used", seen, VEC[v][23:0]);
         chk(fl[DIM +: HW] == HW'(h), "R4", "table hop count", fl[DIM +: HW], h);
      end

      // every pair in the cube: R9 delivery, R4 and R3 hop count, R1 payload
      for (int s = 0; s < NODES; s++) begin
         for (int d = 0; d < NODES; d++) begin
            int h;
            h = $countones(DIM'(s ^ d));
            send_pkt(s, d, PW'({s[2:0], d[2:0]}));
            wait_eject(node, fl, seen, got);
            chk(got && node == d, "R9", "pair eject node", node, d);
            chk(fl[DIM +: HW] == HW'(h), (s == d) ? "R3" : "R4", "pair hop count",
                fl[DIM +: HW], h);
            chk(fl[FW-1 -: PW] == PW'({s[2:0], d[2:0]}) && fl[DIM-1:0] == DIM'(d),
                "R1", "pair payload and dest", fl, {PW'({s[2:0], d[2:0]}), HW'(h), DIM'(d)});
            chk($countones(seen) == h, "R9", "pair links crossed", $countones(seen), h);
         end
      end

      // R7: nodes 1 and 2 both send to 0; they arrive together on ports 0 and 1
      begin
         logic [PW-1:0] got_pay [2];
         int cnt;
         bit port1_waited;
         cnt = 0; port1_waited = 1'b0;
         @(negedge clk);
         inj_f[1] = {8'hA1, HW'(0), DIM'(0)};
         inj_f[2] = {8'hA2, HW'(0), DIM'(0)};
         inj_v[1] = 1'b1; inj_v[2] = 1'b1;
         @(negedge clk);
         inj_v[1] = 1'b0; inj_v[2] = 1'b0;
         for (int c = 0; c < 40 && cnt < 2; c++) begin
            if (n_ov[0][DIM]) begin
               if (cnt == 0) port1_waited = !n_ir[0][1];
               got_pay[cnt] = n_of[0][DIM*FW + FW-1 -: PW];
               cnt++;
            end
            @(negedge clk);
         end
         chk(cnt == 2, "R7", "both delivered", cnt, 2);
         chk(got_pay[0] == 8'hA1, "R7", "lower port first", got_pay[0], 8'hA1);
         chk(got_pay[1] == 8'hA2, "R7", "loser second", got_pay[1], 8'hA2);
         chk(port1_waited, "R7", "loser still stored", port1_waited, 1);
      end

      // R6: eject of node 5 not ready; packet from 0 must wait intact
      begin
         logic [FW-1:0] first;
         bit seen5;
         seen5 = 1'b0;
         ej_r[5] = 1'b0;
         send_pkt(0, 5, 8'h5C);
         for (int c = 0; c < 40 && !seen5; c++) begin
            if (n_ov[5][DIM]) seen5 = 1'b1;
            else @(negedge clk);
         end
         first = n_of[5][DIM*FW +: FW];
         chk(seen5, "R6", "stalled packet offered", seen5, 1);
         chk(first[DIM +: HW] == HW'(2), "R4", "stalled hop", first[DIM +: HW], 2);
         for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk(n_ov[5][DIM] == 1'b1, "R6", "valid held", n_ov[5][DIM], 1);
            chk(n_of[5][DIM*FW +: FW] == first, "R6", "flit held",
                n_of[5][DIM*FW +: FW], first);
         end
         chk(n_ir[5][2] == 1'b0, "R5", "slot full while stalled", n_ir[5][2], 0);
         ej_r[5] = 1'b1;
         @(negedge clk);
         chk(n_ov[5][DIM] == 1'b0, "R6", "released packet taken", n_ov[5][DIM], 0);
         chk(n_ir[5][2] == 1'b1, "R5", "slot empty after take", n_ir[5][2], 1);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule